// File: doc/BRIEF.md
# Receive Destination Filter

This block sits beside a receive datapath and decides, once per frame, whether the frame is kept or thrown away. It watches the frame start strobe, the six destination address octets as they arrive (octet 0 first), and the end-of-frame strobe that carries the final byte count. It then issues a single verdict with a two-bit reason code.

The filter compares the destination against a programmed station address. It can drop unicast frames addressed elsewhere, drop group (multicast and broadcast) frames, or do neither, which is promiscuous reception. It also rejects frames that are too short or longer than a programmable limit. That limit is clamped to a build-time ceiling.

All configuration inputs are captured when a frame starts. A frame that is already under way is judged entirely under the settings that were in force at its start.

Top module: `rxf_dest_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `verdict_valid` is low.
- R2: Every `rx_eof` pulse produces exactly one `verdict_valid` pulse, on the cycle after it. `verdict_code` uses 0 for accept, 1 for address mismatch, 2 for group-address reject and 3 for length reject.
- R3: The station address is assembled as follows. Octets 0 to 3 come from `cfg_addr_lo` bits [7:0], [15:8], [23:16] and [31:24]. Octet 4 comes from `cfg_addr_hi` bits [7:0] and octet 5 from `cfg_addr_hi` bits [15:8]. A destination that differs from it in any single octet counts as a mismatch.
- R4: When `cfg_drop_mismatch` is 1, a unicast destination (bit 0 of octet 0 clear) that differs from the station address gives code 1. An exact match is accepted.
- R5: When `cfg_drop_group` is 1, any destination with bit 0 of octet 0 set, broadcast included, gives code 2.
- R6: Group destinations are never compared with the station address. With both drop enables at 0, every destination is accepted. With only `cfg_drop_group` at 0, broadcast is accepted even though `cfg_drop_mismatch` is 1.
- R7: A frame whose length is below MIN_LEN (64) gives code 3. A length of exactly 64 is accepted.
- R8: A frame longer than the effective limit gives code 3, while a length equal to the limit is accepted. The effective limit is `cfg_max_len`, clamped to LEN_CEIL.
- R9: An address or group reject takes priority over a length reject.
- R10: Configuration is sampled on `rx_sof`. Changes made between a frame's start and its end have no effect on that frame's verdict.
- R11: A frame that ends before all six destination octets were seen gives code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_lo | input | 32 | Station address octets 0 to 3 |
| cfg_addr_hi | input | 16 | Station address octets 4 and 5 |
| cfg_drop_mismatch | input | 1 | Drop unicast frames for other stations |
| cfg_drop_group | input | 1 | Drop group-addressed frames |
| cfg_max_len | input | LEN_W | Maximum accepted frame length in bytes |
| rx_sof | input | 1 | Frame start strobe |
| rx_da_valid | input | 1 | Destination octet valid (on cycles after start) |
| rx_da_byte | input | 8 | Destination octet, octet 0 first |
| rx_eof | input | 1 | Frame end strobe |
| rx_frame_len | input | LEN_W | Final frame length, valid with `rx_eof` |
| verdict_valid | output | 1 | Verdict strobe |
| verdict_code | output | 2 | Verdict reason code |

## Verification
The bench builds the block with LEN_W = 14, LEN_CEIL = 1536 and MIN_LEN = 64. At these values, programming a limit of 4000 exercises the clamp against the ceiling, while still allowing the lower boundary at 63/64 to be tested. The 14-bit length field holds both 1518/1519 and 1536/1537, so the limit boundaries on either side of the clamp can be reached. Mid-frame flips of the mismatch enable, in both directions, show that the start-of-frame snapshot is what decides.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int OCTETS      = 6;
    localparam int LO_OCTETS   = 4;
    localparam int HI_OCT4_LSB = 0;
    localparam int HI_OCT5_LSB = 8;

    typedef logic [OCTETS-1:0][7:0] mac_addr_t;

    typedef enum logic [1:0] {
        VERDICT_ACCEPT = 2'd0,
        VERDICT_ADDR   = 2'd1,
        VERDICT_GROUP  = 2'd2,
        VERDICT_LEN    = 2'd3
    } verdict_e;

    typedef struct packed {
        mac_addr_t station;
        logic      drop_mismatch;
        logic      drop_group;
    } addr_cfg_t;

    // Octet k of the station address; octet 0 is the first on the wire.
    function automatic mac_addr_t pack_station(input logic [31:0] lo,
                                               input logic [15:0] hi);
        mac_addr_t a;
        for (int k = 0; k < LO_OCTETS; k++) begin
            a[k] = lo[8*k +: 8];
        end
        a[4] = hi[HI_OCT4_LSB +: 8];
        a[5] = hi[HI_OCT5_LSB +: 8];
        return a;
    endfunction

    // Address-stage decision: group rule first, unicast mismatch second.
    function automatic verdict_e addr_decide(input logic group,
                                             input logic differ,
                                             input addr_cfg_t cfg);
        if (group && cfg.drop_group)
            return VERDICT_GROUP;
        else if (!group && differ && cfg.drop_mismatch)
            return VERDICT_ADDR;
        else
            return VERDICT_ACCEPT;
    endfunction

endpackage

// File: rtl/rxf_cfg_snap.sv
module rxf_cfg_snap
    import rxf_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int LEN_CEIL = 1536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic [31:0]      addr_lo,
    input  logic [15:0]      addr_hi,
    input  logic             drop_mismatch,
    input  logic             drop_group,
    input  logic [LEN_W-1:0] max_len,
    output addr_cfg_t        cfg_q,
    output logic [LEN_W-1:0] max_q
);
    localparam logic [LEN_W-1:0] CEIL_V = LEN_W'(LEN_CEIL);

    logic [LEN_W-1:0] max_clamped;

    always_comb begin
        max_clamped = (max_len > CEIL_V) ? CEIL_V : max_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            max_q <= CEIL_V;
        end else if (sof) begin
            cfg_q.station       <= pack_station(addr_lo, addr_hi);
            cfg_q.drop_mismatch <= drop_mismatch;
            cfg_q.drop_group    <= drop_group;
            max_q               <= max_clamped;
        end
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !sof |=> ($stable(cfg_q) && $stable(max_q)));

    assert_max_capped_R8: assert property (@(posedge clk) disable iff (rst)
        max_q <= CEIL_V);

endmodule

// File: rtl/rxf_da_match.sv
module rxf_da_match
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      da_valid,
    input  logic [7:0] da_byte,
    input  addr_cfg_t cfg,
    output logic      done,
    output verdict_e  reason
);
    localparam int CNT_W = $clog2(OCTETS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OCTETS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OCTETS - 1);

    logic [CNT_W-1:0] cnt;
    logic             differ;
    logic             group;
    logic             take;
    logic             last;
    logic [7:0]       exp_byte;
    logic             differ_now;
    logic             group_now;

    always_comb begin
        exp_byte = '0;
        for (int k = 0; k < OCTETS; k++) begin
            if (cnt == CNT_W'(k)) exp_byte = cfg.station[k];
        end
        take       = da_valid && !sof && (cnt < CNT_FULL);
        last       = take && (cnt == CNT_LAST);
        differ_now = differ || (da_byte != exp_byte);
        group_now  = (cnt == '0) ? da_byte[0] : group;
    end

    always_ff @(posedge clk) begin
        if (rst || sof) begin
            cnt    <= '0;
            differ <= 1'b0;
            group  <= 1'b0;
            done   <= 1'b0;
            reason <= VERDICT_ACCEPT;
        end else if (take) begin
            cnt    <= cnt + CNT_W'(1);
            differ <= differ_now;
            group  <= group_now;
            if (last) begin
                done   <= 1'b1;
                reason <= addr_decide(group_now, differ_now, cfg);
            end
        end
    end

    assert_done_full_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == CNT_FULL));

    assert_sof_clears_R10: assert property (@(posedge clk) disable iff (rst)
        sof |=> !done);

    assert_group_drop_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && group && cfg.drop_group) |-> (reason == VERDICT_GROUP));

    assert_group_no_compare_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && group && !cfg.drop_group) |-> (reason == VERDICT_ACCEPT));

endmodule

// File: rtl/rxf_len_judge.sv
module rxf_len_judge
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eof,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic             addr_done,
    input  verdict_e         addr_reason,
    output logic             vld,
    output verdict_e         code
);
    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

    logic     len_bad;
    verdict_e next_code;

    always_comb begin
        len_bad = (frame_len < MIN_V) || (frame_len > max_len);
        if (!addr_done)
            next_code = VERDICT_LEN;
        else if (addr_reason != VERDICT_ACCEPT)
            next_code = addr_reason;
        else if (len_bad)
            next_code = VERDICT_LEN;
        else
            next_code = VERDICT_ACCEPT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            code <= VERDICT_ACCEPT;
        end else begin
            vld <= eof;
            if (eof) code <= next_code;
        end
    end

    assert_verdict_follows_R2: assert property (@(posedge clk) disable iff (rst)
        eof |=> vld);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !eof |=> !vld);

    assert_short_len_R7: assert property (@(posedge clk) disable iff (rst)
        (eof && addr_done && addr_reason == VERDICT_ACCEPT && frame_len < MIN_V)
        |=> (code == VERDICT_LEN));

    assert_addr_priority_R9: assert property (@(posedge clk) disable iff (rst)
        (eof && addr_done && addr_reason != VERDICT_ACCEPT)
        |=> (code == $past(addr_reason)));

    assert_runt_R11: assert property (@(posedge clk) disable iff (rst)
        (eof && !addr_done) |=> (code == VERDICT_LEN));

endmodule

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int LEN_CEIL = 1536,
    parameter int MIN_LEN  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cfg_addr_lo,
    input  logic [15:0]      cfg_addr_hi,
    input  logic             cfg_drop_mismatch,
    input  logic             cfg_drop_group,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             rx_sof,
    input  logic             rx_da_valid,
    input  logic [7:0]       rx_da_byte,
    input  logic             rx_eof,
    input  logic [LEN_W-1:0] rx_frame_len,
    output logic             verdict_valid,
    output logic [1:0]       verdict_code
);
    addr_cfg_t        cfg_snap;
    logic [LEN_W-1:0] max_snap;
    logic             addr_done;
    verdict_e         addr_reason;
    verdict_e         final_code;

    rxf_cfg_snap #(
        .LEN_W    (LEN_W),
        .LEN_CEIL (LEN_CEIL)
    ) u_snap (
        .clk           (clk),
        .rst           (rst),
        .sof           (rx_sof),
        .addr_lo       (cfg_addr_lo),
        .addr_hi       (cfg_addr_hi),
        .drop_mismatch (cfg_drop_mismatch),
        .drop_group    (cfg_drop_group),
        .max_len       (cfg_max_len),
        .cfg_q         (cfg_snap),
        .max_q         (max_snap)
    );

    rxf_da_match u_match (
        .clk      (clk),
        .rst      (rst),
        .sof      (rx_sof),
        .da_valid (rx_da_valid),
        .da_byte  (rx_da_byte),
        .cfg      (cfg_snap),
        .done     (addr_done),
        .reason   (addr_reason)
    );

    rxf_len_judge #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_judge (
        .clk         (clk),
        .rst         (rst),
        .eof         (rx_eof),
        .frame_len   (rx_frame_len),
        .max_len     (max_snap),
        .addr_done   (addr_done),
        .addr_reason (addr_reason),
        .vld         (verdict_valid),
        .code        (final_code)
    );

    assign verdict_code = final_code;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !verdict_valid);

endmodule

// File: tb/rxf_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rxf_dest_filter_tb_top;
    localparam int LEN_W    = 14;
    localparam int LEN_CEIL = 1536;
    localparam int MIN_LEN  = 64;

    logic             clk = 1'b0;
    logic             rst;
    logic [31:0]      cfg_addr_lo;
    logic [15:0]      cfg_addr_hi;
    logic             cfg_drop_mismatch;
    logic             cfg_drop_group;
    logic [LEN_W-1:0] cfg_max_len;
    logic             rx_sof;
    logic             rx_da_valid;
    logic [7:0]       rx_da_byte;
    logic             rx_eof;
    logic [LEN_W-1:0] rx_frame_len;
    logic             verdict_valid;
    logic [1:0]       verdict_code;

    always #2.5 clk = ~clk;

    rxf_dest_filter #(
        .LEN_W    (LEN_W),
        .LEN_CEIL (LEN_CEIL),
        .MIN_LEN  (MIN_LEN)
    ) dut_i (
        .clk               (clk),
        .rst               (rst),
        .cfg_addr_lo       (cfg_addr_lo),
        .cfg_addr_hi       (cfg_addr_hi),
        .cfg_drop_mismatch (cfg_drop_mismatch),
        .cfg_drop_group    (cfg_drop_group),
        .cfg_max_len       (cfg_max_len),
        .rx_sof            (rx_sof),
        .rx_da_valid       (rx_da_valid),
        .rx_da_byte        (rx_da_byte),
        .rx_eof            (rx_eof),
        .rx_frame_len      (rx_frame_len),
        .verdict_valid     (verdict_valid),
        .verdict_code      (verdict_code)
    );

    typedef struct {
        logic [1:0] code;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t got;
    int   n_checks = 0;
    int   n_fail   = 0;
    logic eof_q    = 1'b0;

    // Monitor: verdict must follow each end strobe by one cycle (R2).
    always @(posedge clk) eof_q <= rx_eof;

    always @(negedge clk) begin
        if (!rst) begin
            if (verdict_valid !== eof_q) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 verdict_valid=%0b expected %0b", verdict_valid, eof_q);
            end
            if (verdict_valid === 1'b1) begin
                n_checks++;
                if (sb_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 unexpected verdict code=%0d expected none", verdict_code);
                end else begin
                    got = sb_q.pop_front();
                    if (verdict_code !== got.code) begin
                        n_fail++;
                        $display("FAIL %s code=%0d expected %0d", got.tag, verdict_code, got.code);
                    end
                end
            end
        end
    end

    function automatic logic [47:0] mac(input logic [7:0] b0, input logic [7:0] b1,
                                        input logic [7:0] b2, input logic [7:0] b3,
                                        input logic [7:0] b4, input logic [7:0] b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Driver: queue the expected verdict, then play one frame.
    task automatic send(input logic [47:0] da, input int nbytes, input int len,
                        input logic [1:0] code, input string tag, input int flip_at);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        sb_q.push_back(e);
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        for (int k = 0; k < nbytes; k++) begin
            if (k == flip_at) cfg_drop_mismatch = ~cfg_drop_mismatch;
            rx_da_valid = 1'b1;
            rx_da_byte  = da[8*k +: 8];
            @(negedge clk);
        end
        rx_da_valid = 1'b0;
        @(negedge clk);
        rx_eof       = 1'b1;
        rx_frame_len = LEN_W'(len);
        @(negedge clk);
        rx_eof = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] stn;
        logic [47:0] other;
        rst               = 1'b1;
        cfg_addr_lo       = 32'h3322_1102;
        cfg_addr_hi       = 16'h5544;
        cfg_drop_mismatch = 1'b1;
        cfg_drop_group    = 1'b1;
        cfg_max_len       = LEN_W'(1518);
        rx_sof            = 1'b0;
        rx_da_valid       = 1'b0;
        rx_da_byte        = '0;
        rx_eof            = 1'b0;
        rx_frame_len      = '0;
        stn   = mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        other = mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
        repeat (4) @(negedge clk);
        n_checks++;
        if (verdict_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 verdict_valid=%0b expected 0", verdict_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (verdict_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset verdict_valid=%0b expected 0", verdict_valid);
        end

        // R3/R4: exact match accepted; last octet and octet 4 mismatches rejected
        send(stn, 6, 100, 2'd0, "R4 exact match", -1);
        send(other, 6, 100, 2'd1, "R4 octet5 mismatch", -1);
        send(mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h45, 8'h55), 6, 100, 2'd1, "R3 octet4 mismatch", -1);
        send(mac(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 6, 100, 2'd2, "R3 octet0 group bit", -1);
        // R5: multicast and broadcast dropped
        send(mac(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01), 6, 100, 2'd2, "R5 multicast", -1);
        send(48'hFFFF_FFFF_FFFF, 6, 100, 2'd2, "R5 broadcast", -1);
        // R6: group enable off, broadcast passes though mismatch enable is on
        cfg_drop_group = 1'b0;
        send(48'hFFFF_FFFF_FFFF, 6, 100, 2'd0, "R6 broadcast accepted", -1);
        // R6: promiscuous
        cfg_drop_mismatch = 1'b0;
        send(other, 6, 100, 2'd0, "R6 promiscuous unicast", -1);
        send(mac(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h09), 6, 100, 2'd0, "R6 promiscuous multicast", -1);
        cfg_drop_mismatch = 1'b1;
        cfg_drop_group    = 1'b1;
        // R7: minimum length boundary
        send(stn, 6, 63, 2'd3, "R7 length 63", -1);
        send(stn, 6, 64, 2'd0, "R7 length 64", -1);
        // R8: programmed limit boundary
        send(stn, 6, 1518, 2'd0, "R8 length at limit", -1);
        send(stn, 6, 1519, 2'd3, "R8 length over limit", -1);
        // R8: limit clamped to ceiling
        cfg_max_len = LEN_W'(4000);
        send(stn, 6, 1536, 2'd0, "R8 length at ceiling", -1);
        send(stn, 6, 1537, 2'd3, "R8 length over ceiling", -1);
        cfg_max_len = LEN_W'(1518);
        // R9: address reject wins over length reject
        send(other, 6, 20, 2'd1, "R9 mismatch beats short", -1);
        send(48'hFFFF_FFFF_FFFF, 6, 3000, 2'd2, "R9 group beats long", -1);
        // R10: mid-frame change of the mismatch enable, both directions
        send(other, 6, 100, 2'd1, "R10 disable mid-frame", 2);
        send(other, 6, 100, 2'd0, "R10 enable mid-frame", 2);
        cfg_drop_mismatch = 1'b1;
        // R11: frame ends after only three octets
        send(stn, 3, 100, 2'd3, "R11 short address", -1);

        repeat (5) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing verdicts=%0d expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule